// File: doc/BRIEF.md
# Integer Shift and Arithmetic Execution Unit

A purely combinational 32-bit execution unit for a simple load/store integer core. It takes two operands, a 4-bit operation code, a constant shift amount and a flag that picks where a shift or rotate distance comes from. It returns a 32-bit result and an overflow flag in the same cycle. The pipeline captures the result and feeds the overflow flag to its exception logic.

Add, subtract and negate each come in a checked form and an unchecked form. Both forms give the same wrapped result. Only the checked form reports two's-complement overflow. Absolute value is always checked.

The unit also provides the bitwise operations and a single barrel network. That network serves logical shifts, arithmetic shifts and rotates in both directions, with either an immediate distance or a distance taken from the second operand.

Top module: `alu_exec`

## Requirements
- R1: `op_i` selects the operation: 0 ADD, 1 ADDU, 2 SUB, 3 SUBU, 4 NEG, 5 NEGU, 6 ABS, 7 AND, 8 OR, 9 NOR, 10 NOT, 11 SLL, 12 SRL, 13 SRA, 14 ROL, 15 ROR.
- R2: ADD gives `a_i+b_i` and SUB gives `a_i-b_i`, both modulo 2^32. `ovf_o` is 1 exactly when the signed result does not fit in 32 bits.
- R3: ADDU, SUBU and NEGU give the same result as their checked forms, and `ovf_o` is 0 for them.
- R4: NEG gives `0-a_i`. `ovf_o` is 1 only for `a_i`=0x80000000.
- R5: ABS gives the magnitude of signed `a_i`. For `a_i`=0x80000000 the result is 0x80000000 and `ovf_o` is 1; for every other value `ovf_o` is 0.
- R6: AND, OR and NOR combine `a_i` and `b_i` bitwise. NOT gives `~a_i` and ignores `b_i`.
- R7: SLL shifts `a_i` left and SRL shifts it right, and both fill the vacated bits with zeros.
- R8: SRA shifts `a_i` right and fills the vacated bits with `a_i[31]`.
- R9: With `amt_sel_i`=0 the shift or rotate distance is `shamt_i`. With `amt_sel_i`=1 it is `b_i[4:0]`, and `b_i[31:5]` has no effect.
- R10: ROL and ROR move the bits of `a_i` circularly left or right by the distance. A distance of 0 returns `a_i`.
- R11: `ovf_o` is 0 for all bitwise, shift and rotate operations (codes 7 to 15).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand; the value that is shifted or rotated |
| b_i | input | 32 | Second operand; low 5 bits give the variable distance |
| op_i | input | 4 | Operation code |
| shamt_i | input | 5 | Constant shift or rotate distance |
| amt_sel_i | input | 1 | 1: distance from `b_i[4:0]`; 0: distance from `shamt_i` |
| result_o | output | 32 | Operation result |
| ovf_o | output | 1 | Checked signed overflow |

## Verification
The hardest cases to reach are the single operand values at which overflow appears for negate and absolute value, and the add and subtract sign combinations that sit just past the signed limits. The bench drives 0x80000000, 0x7FFFFFFF and their neighbours through both the checked and unchecked codes. It also drives variable-distance shifts with garbage in the upper bits of `b_i`, so that any use of those bits shows up in the result.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned XLEN = 32;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDU = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBU = 4'd3,
    OP_NEG  = 4'd4,
    OP_NEGU = 4'd5,
    OP_ABS  = 4'd6,
    OP_AND  = 4'd7,
    OP_OR   = 4'd8,
    OP_NOR  = 4'd9,
    OP_NOT  = 4'd10,
    OP_SLL  = 4'd11,
    OP_SRL  = 4'd12,
    OP_SRA  = 4'd13,
    OP_ROL  = 4'd14,
    OP_ROR  = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    LOGIC_AND = 2'd0,
    LOGIC_OR  = 2'd1,
    LOGIC_NOR = 2'd2,
    LOGIC_NOT = 2'd3
  } logic_fn_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);
  logic [W-1:0] y_eff;

  assign y_eff = y_i ^ {W{sub_i}};
  assign sum_o = x_i + y_eff + {{(W-1){1'b0}}, sub_i};
  // signed overflow: equal operand signs, different result sign
  assign ovf_o = (x_i[W-1] == y_eff[W-1]) && (sum_o[W-1] != x_i[W-1]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_fn_e    fn_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (fn_i)
      LOGIC_AND: res_o = a_i & b_i;
      LOGIC_OR:  res_o = a_i | b_i;
      LOGIC_NOR: res_o = ~(a_i | b_i);
      default:   res_o = ~a_i;
    endcase
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  val_i,
  input  logic [SW-1:0] amt_i,
  input  logic          left_i,
  input  logic          arith_i,
  input  logic          rot_i,
  output logic [W-1:0]  res_o
);
  logic [SW:0][W-1:0] stg;
  logic [W-1:0]       val_rev;
  logic [W-1:0]       out_rev;
  logic               fill;

  // left operations run through the right network on bit-reversed data
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign val_rev[i] = val_i[W-1-i];
    assign out_rev[i] = stg[SW][W-1-i];
  end

  assign stg[0] = left_i ? val_rev : val_i;
  assign fill   = arith_i & ~left_i & ~rot_i & val_i[W-1];

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int unsigned D = 1 << s;
    logic [D-1:0] top_bits;
    assign top_bits   = rot_i ? stg[s][D-1:0] : {D{fill}};
    assign stg[s+1]   = amt_i[s] ? {top_bits, stg[s][W-1:D]} : stg[s];
  end

  assign res_o = left_i ? out_rev : stg[SW];
endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_pkg::*;
#(
  parameter int unsigned W  = XLEN,
  parameter int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [3:0]    op_i,
  input  logic [SW-1:0] shamt_i,
  input  logic          amt_sel_i,
  output logic [W-1:0]  result_o,
  output logic          ovf_o
);
  alu_op_e      op;
  logic [W-1:0] add_x, add_y, add_sum, logic_res, shift_res;
  logic         add_sub, add_ovf, checked;
  logic         is_arith, is_logic;
  logic_fn_e    logic_fn;
  logic [SW-1:0] amt;
  logic         sh_left, sh_arith, sh_rot;

  assign op = alu_op_e'(op_i);

  always_comb begin
    add_x   = a_i;
    add_y   = b_i;
    add_sub = 1'b0;
    unique case (op)
      OP_SUB, OP_SUBU: add_sub = 1'b1;
      OP_NEG, OP_NEGU: begin
        add_x   = '0;
        add_y   = a_i;
        add_sub = 1'b1;
      end
      OP_ABS: begin
        add_x   = '0;
        add_y   = a_i;
        add_sub = a_i[W-1];
      end
      default: ;
    endcase
  end

  alu_addsub #(.W(W)) u_addsub (
    .x_i(add_x), .y_i(add_y), .sub_i(add_sub),
    .sum_o(add_sum), .ovf_o(add_ovf)
  );

  always_comb begin
    unique case (op)
      OP_OR:   logic_fn = LOGIC_OR;
      OP_NOR:  logic_fn = LOGIC_NOR;
      OP_NOT:  logic_fn = LOGIC_NOT;
      default: logic_fn = LOGIC_AND;
    endcase
  end

  alu_logic #(.W(W)) u_logic (
    .a_i(a_i), .b_i(b_i), .fn_i(logic_fn), .res_o(logic_res)
  );

  assign amt      = amt_sel_i ? b_i[SW-1:0] : shamt_i;
  assign sh_left  = (op == OP_SLL) || (op == OP_ROL);
  assign sh_arith = (op == OP_SRA);
  assign sh_rot   = (op == OP_ROL) || (op == OP_ROR);

  alu_shifter #(.W(W), .SW(SW)) u_shift (
    .val_i(a_i), .amt_i(amt), .left_i(sh_left), .arith_i(sh_arith),
    .rot_i(sh_rot), .res_o(shift_res)
  );

  assign is_arith = (op_i <= 4'(OP_ABS));
  assign is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_NOR) || (op == OP_NOT);
  assign checked  = (op == OP_ADD) || (op == OP_SUB) || (op == OP_NEG) || (op == OP_ABS);

  assign result_o = is_arith ? add_sum : (is_logic ? logic_res : shift_res);
  assign ovf_o    = checked & add_ovf;
endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk
  import alu_pkg::*;
#(
  parameter int unsigned W  = XLEN,
  parameter int unsigned SW = $clog2(W)
) (
  input logic [W-1:0]  a_i,
  input logic [W-1:0]  b_i,
  input logic [3:0]    op_i,
  input logic [SW-1:0] shamt_i,
  input logic          amt_sel_i,
  input logic [W-1:0]  result_o,
  input logic          ovf_o
);
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    if (op_i == 4'(OP_ADDU) || op_i == 4'(OP_SUBU) || op_i == 4'(OP_NEGU))
      a_r3_unchecked_no_ovf: assert (!ovf_o) else $error("R3 unchecked op flagged overflow");
    if (op_i >= 4'(OP_AND))
      a_r11_no_ovf: assert (!ovf_o) else $error("R11 overflow on non-arith op");
    if (op_i == 4'(OP_ADD) || op_i == 4'(OP_ADDU))
      a_r2_add_sum: assert (result_o == a_i + b_i) else $error("R2 sum mismatch");
    if (op_i == 4'(OP_NEG))
      a_r4_neg_ovf: assert (ovf_o == (a_i == MIN_NEG)) else $error("R4 negate overflow wrong");
    if (op_i == 4'(OP_ABS) && !a_i[W-1])
      a_r5_abs_pos: assert (result_o == a_i && !ovf_o) else $error("R5 abs of non-negative");
    if (op_i == 4'(OP_NOT))
      a_r6_not: assert (result_o == ~a_i) else $error("R6 not mismatch");
    if ((op_i == 4'(OP_ROL) || op_i == 4'(OP_ROR)) &&
        ((amt_sel_i ? b_i[SW-1:0] : shamt_i) == '0))
      a_r10_rot_zero: assert (result_o == a_i) else $error("R10 zero rotate");
  end
endmodule

bind alu_exec alu_exec_chk #(.W(W), .SW(SW)) u_chk (
  .a_i(a_i), .b_i(b_i), .op_i(op_i), .shamt_i(shamt_i),
  .amt_sel_i(amt_sel_i), .result_o(result_o), .ovf_o(ovf_o)
);

// File: tb/tb_alu_exec.sv
`timescale 1ns/1ps
module tb_alu_exec;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] a, b, res;
  logic [3:0]  op;
  logic [4:0]  sh;
  logic        sel, ovf;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  alu_exec dut (
    .a_i(a), .b_i(b), .op_i(op), .shamt_i(sh), .amt_sel_i(sel),
    .result_o(res), .ovf_o(ovf)
  );

  task automatic apply(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic [4:0] s, input logic v);
    @(negedge clk);
    op = o; a = x; b = y; sh = s; sel = v;
    #2;
  endtask

  task automatic check(input string tag, input logic [31:0] er, input logic eo);
    checks++;
    if (res !== er || ovf !== eo) begin
      fails++;
      $display("FAIL %s: result=%h ovf=%b expected result=%h ovf=%b", tag, res, ovf, er, eo);
    end
  endtask

  function automatic logic [31:0] rotl(input logic [31:0] x, input int n);
    return (n == 0) ? x : ((x << n) | (x >> (32 - n)));
  endfunction

  task automatic t_idle;  // R1: code 0 is ADD, zero operands give zero
    apply(4'd0, 32'h0, 32'h0, 5'd0, 1'b0);
    check("R1 idle zero", 32'h0, 1'b0);
  endtask

  task automatic t_add;
    apply(4'd0, 32'h7FFFFFFF, 32'h1, 5'd0, 1'b0); check("R2 add pos ovf", 32'h80000000, 1'b1);
    apply(4'd0, 32'h80000000, 32'hFFFFFFFF, 5'd0, 1'b0); check("R2 add neg ovf", 32'h7FFFFFFF, 1'b1);
    apply(4'd0, 32'h7FFFFFFE, 32'h1, 5'd0, 1'b0); check("R2 add edge no ovf", 32'h7FFFFFFF, 1'b0);
    apply(4'd0, 32'hFFFFFFFF, 32'h1, 5'd0, 1'b0); check("R2 add carry no ovf", 32'h0, 1'b0);
    apply(4'd1, 32'h7FFFFFFF, 32'h1, 5'd0, 1'b0); check("R3 addu no ovf", 32'h80000000, 1'b0);
  endtask

  task automatic t_sub;
    apply(4'd2, 32'h80000000, 32'h1, 5'd0, 1'b0); check("R2 sub ovf", 32'h7FFFFFFF, 1'b1);
    apply(4'd2, 32'h0, 32'h80000000, 5'd0, 1'b0); check("R2 sub min ovf", 32'h80000000, 1'b1);
    apply(4'd2, 32'h5, 32'h7, 5'd0, 1'b0); check("R2 sub small", 32'hFFFFFFFE, 1'b0);
    apply(4'd3, 32'h80000000, 32'h1, 5'd0, 1'b0); check("R3 subu no ovf", 32'h7FFFFFFF, 1'b0);
  endtask

  task automatic t_neg;
    apply(4'd4, 32'h80000000, 32'h0, 5'd0, 1'b0); check("R4 neg min ovf", 32'h80000000, 1'b1);
    apply(4'd4, 32'h80000001, 32'h0, 5'd0, 1'b0); check("R4 neg", 32'h7FFFFFFF, 1'b0);
    apply(4'd4, 32'h0, 32'h0, 5'd0, 1'b0); check("R4 neg zero", 32'h0, 1'b0);
    apply(4'd5, 32'h80000000, 32'h0, 5'd0, 1'b0); check("R3 negu min", 32'h80000000, 1'b0);
  endtask

  task automatic t_abs;
    apply(4'd6, 32'h80000000, 32'h0, 5'd0, 1'b0); check("R5 abs min", 32'h80000000, 1'b1);
    apply(4'd6, 32'hFFFFFFF9, 32'h0, 5'd0, 1'b0); check("R5 abs neg", 32'h7, 1'b0);
    apply(4'd6, 32'h7FFFFFFF, 32'h0, 5'd0, 1'b0); check("R5 abs pos", 32'h7FFFFFFF, 1'b0);
  endtask

  task automatic t_logic;
    apply(4'd7, 32'hF0F0_1234, 32'hFF00_FF0F, 5'd0, 1'b0); check("R6 and", 32'hF000_1204, 1'b0);
    apply(4'd8, 32'hF0F0_1234, 32'h0F00_0001, 5'd0, 1'b0); check("R6 or", 32'hFFF0_1235, 1'b0);
    apply(4'd9, 32'hF0F0_0000, 32'h0000_000F, 5'd0, 1'b0); check("R6 nor", 32'h0F0F_FFF0, 1'b0);
    apply(4'd10, 32'h1234_5678, 32'hDEAD_BEEF, 5'd0, 1'b0); check("R6 not ignores b", 32'hEDCB_A987, 1'b0);
    apply(4'd9, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0, 1'b0); check("R11 nor no ovf", 32'h0, 1'b0);
  endtask

  task automatic t_shift;
    for (int n = 0; n < 32; n += 7) begin
      apply(4'd11, 32'h8000_00F1, 32'h0, 5'(n), 1'b0);
      check("R7 sll const", 32'h8000_00F1 << n, 1'b0);
      apply(4'd12, 32'h8000_00F1, 32'h0, 5'(n), 1'b0);
      check("R7 srl const", 32'h8000_00F1 >> n, 1'b0);
      apply(4'd13, 32'h8000_00F1, 32'h0, 5'(n), 1'b0);
      check("R8 sra neg", 32'($signed(32'h8000_00F1) >>> n), 1'b0);
    end
    apply(4'd13, 32'h4000_0000, 32'h0, 5'd31, 1'b0); check("R8 sra pos", 32'h0, 1'b0);
    apply(4'd13, 32'hC000_0000, 32'h0, 5'd31, 1'b0); check("R11 sra full", 32'hFFFF_FFFF, 1'b0);
  endtask

  task automatic t_amt_src;
    apply(4'd11, 32'h1, 32'hFFFF_FFE4, 5'd1, 1'b1); check("R9 var sll upper b ignored", 32'h10, 1'b0);
    apply(4'd12, 32'h8000_0000, 32'hABCD_EF1F, 5'd0, 1'b1); check("R9 var srl 31", 32'h1, 1'b0);
    apply(4'd11, 32'h1, 32'h0000_0003, 5'd8, 1'b0); check("R9 const ignores b", 32'h100, 1'b0);
    apply(4'd13, 32'h8000_0000, 32'hFFFF_FFE0, 5'd4, 1'b1); check("R9 var sra zero dist", 32'h8000_0000, 1'b0);
  endtask

  task automatic t_rot;
    for (int n = 0; n < 32; n += 5) begin
      apply(4'd14, 32'h8765_4321, 32'h0, 5'(n), 1'b0);
      check("R10 rol", rotl(32'h8765_4321, n), 1'b0);
      apply(4'd15, 32'h8765_4321, 32'hFFFF_FFE0 | 32'(n), 5'd0, 1'b1);
      check("R10 ror var", rotl(32'h8765_4321, (32 - n) % 32), 1'b0);
    end
    apply(4'd15, 32'h0000_0001, 32'h0, 5'd1, 1'b0); check("R10 ror wrap", 32'h8000_0000, 1'b0);
  endtask

  initial begin
    a = '0; b = '0; op = '0; sh = '0; sel = 1'b0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    t_idle();
    t_add();
    t_sub();
    t_neg();
    t_abs();
    t_logic();
    t_shift();
    t_amt_src();
    t_rot();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule